// File: doc/BRIEF.md
# Prescaled Modulo Timer

This block is a register-mapped up-counting timer for use as a periodic or one-shot event source. Software reaches it through a simple synchronous bus: writes are captured on the rising clock edge when `wr_en` is high, and reads are combinational, so `rdata` shows the register chosen by `addr` in the same cycle. The counter advances once per prescaled tick. The tick rate is the system clock divided by a selectable power of two. The counter climbs from a start value to a modulo value, then reloads the start value and raises a sticky overflow flag. When that flag is enabled it drives a level interrupt.

The modulo and start values are double-buffered. Bus writes always land in shadow copies. The counter compares against and reloads from active copies, and these take the shadow contents only while the clock-select field reads zero. A period can therefore be changed while the counter runs without a torn compare. The change takes effect after the next stop. Any write to the counter register reloads it from the active start value, so a new interval begins from a known point.

The bus carries only register accesses and has no streaming data path. All pins are therefore plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `prescaled_modulo_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The register map uses byte addresses: control at 0x00, counter at 0x04, modulo at 0x08 and start value at 0x4C. Any other address reads 0, and writes to it are ignored. Counter, modulo and start are 16 bits wide and read back with bits [31:16] zero; write data bits [31:16] are dropped.
- R3: Control bits [2:0] hold a prescale exponent `ps`. While running, the counter ticks once every 2^ps clock cycles. The first tick lands 2^ps cycles after the edge that enabled it.
- R4: On each tick the counter adds 1, except when it equals the active modulo; then it reloads the active start value.
- R5: The overflow flag (control bit 7) sets on exactly the tick that reloads from modulo to start, and it stays set until software clears it.
- R6: Control bits [4:3] select the counter clock. The value 1 runs the counter. Any other value (0, 2 or 3) holds the counter and returns the prescaler phase to zero.
- R7: A write of any data to the counter register loads the active start value on that edge. This load takes priority over a tick in the same cycle.
- R8: Writes to modulo and start go to shadow registers, and reads of those addresses return the shadow. The active copies take the shadow values only on edges where the clock-select field is 0.
- R9: Writing 0 to control bit 7 clears the flag, and writing 1 leaves it as it is. If a wrap lands on the same edge as a clear, the flag stays set.
- R10: Control bit 6 enables the interrupt. `irq` is high exactly when both the flag and the enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| addr | input | 8 | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Overflow interrupt level |

## Verification
The sweep covers prescale exponents 0 to 3, several modulo values including 0, and zero and non-zero start values, checking the count and flag on every cycle of two full periods. An off-by-one in the prescaler or the wrap compare would shift the count or the flag by one tick. A counter-register write is issued mid-count to show that it reloads the start value, overriding a tick that lands on the same edge. A modulo change is made while running: a design that let it through at once would wrap at the new value too early. A stop/restart at an odd prescaler phase exposes a divider that is not cleared when stopped. A flag clear timed onto a wrap, and a write of 1 to the flag, expose a flag that loses events or can be set by software.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned PS_W  = 3;
  localparam int unsigned SEL_W = 2;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h04;
  localparam logic [7:0] OFS_MODULO = 8'h08;
  localparam logic [7:0] OFS_START  = 8'h4C;

  localparam logic [SEL_W-1:0] SEL_STOP = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SYS  = 2'd1;

  typedef struct packed {
    logic             ovf;
    logic             ovf_ie;
    logic             rsvd;
    logic [SEL_W-1:0] sel;
    logic [PS_W-1:0]  ps;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int unsigned EXP_W = PS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] ps,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = (DIV_W'(1) << ps) - DIV_W'(1);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)   div_q <= '0;
    else if (run) div_q <= div_q + DIV_W'(1);
    else          div_q <= '0;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load_en,
  input  logic          cnt_wr,
  input  logic [CW-1:0] mod_buf,
  input  logic [CW-1:0] start_buf,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] mod_act,
  output logic [CW-1:0] start_act,
  output logic          wrap
);
  localparam int unsigned NBUF = 2;

  logic [NBUF-1:0][CW-1:0] shadow;
  logic [NBUF-1:0][CW-1:0] active;

  assign shadow[0] = mod_buf;
  assign shadow[1] = start_buf;

  for (genvar i = 0; i < NBUF; i++) begin : g_active
    always_ff @(posedge clk) begin
      if (!rst_n)       active[i] <= '0;
      else if (load_en) active[i] <= shadow[i];
    end
  end

  assign mod_act   = active[0];
  assign start_act = active[1];

  assign wrap = tick && !cnt_wr && (cnt == mod_act);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_wr) cnt <= start_act;
    else if (tick)   cnt <= (cnt == mod_act) ? start_act : cnt + CW'(1);
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [CW-1:0]    cnt,
  input  logic             ovf_evt,
  output logic [DW-1:0]    rdata,
  output logic [PS_W-1:0]  ps,
  output logic [SEL_W-1:0] sel,
  output logic             ie,
  output logic             flag,
  output logic [CW-1:0]    mod_buf,
  output logic [CW-1:0]    start_buf,
  output logic             cnt_wr
);
  logic  hit_ctrl, hit_cnt, hit_mod, hit_start;
  logic  ctrl_wr;
  ctrl_t wr_ctrl;
  ctrl_t rd_ctrl;
  logic  unused_wbits;

  assign hit_ctrl  = (addr == AW'(OFS_CTRL));
  assign hit_cnt   = (addr == AW'(OFS_COUNT));
  assign hit_mod   = (addr == AW'(OFS_MODULO));
  assign hit_start = (addr == AW'(OFS_START));

  assign ctrl_wr = wr_en && hit_ctrl;
  assign cnt_wr  = wr_en && hit_cnt;
  assign wr_ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
  assign unused_wbits = ^{wdata[DW-1:CW], wr_ctrl.rsvd};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps  <= '0;
      sel <= SEL_STOP;
      ie  <= 1'b0;
    end else if (ctrl_wr) begin
      ps  <= wr_ctrl.ps;
      sel <= wr_ctrl.sel;
      ie  <= wr_ctrl.ovf_ie;
    end
  end

  // a wrap on the clearing edge wins; writing 1 never sets the flag
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= ovf_evt || (flag && !(ctrl_wr && !wr_ctrl.ovf));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_buf   <= '0;
      start_buf <= '0;
    end else if (wr_en) begin
      if (hit_mod)   mod_buf   <= wdata[CW-1:0];
      if (hit_start) start_buf <= wdata[CW-1:0];
    end
  end

  always_comb begin
    rd_ctrl.ovf    = flag;
    rd_ctrl.ovf_ie = ie;
    rd_ctrl.rsvd   = 1'b0;
    rd_ctrl.sel    = sel;
    rd_ctrl.ps     = ps;
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl)       rdata = {{(DW-CTRL_W){1'b0}}, rd_ctrl};
    else if (hit_cnt)   rdata = {{(DW-CW){1'b0}}, cnt};
    else if (hit_mod)   rdata = {{(DW-CW){1'b0}}, mod_buf};
    else if (hit_start) rdata = {{(DW-CW){1'b0}}, start_buf};
  end
endmodule

// File: rtl/prescaled_modulo_timer.sv
module prescaled_modulo_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [PS_W-1:0]  ps;
  logic [SEL_W-1:0] clksel;
  logic             ie;
  logic             flag;
  logic [CW-1:0]    mod_buf, start_buf;
  logic [CW-1:0]    cnt_q, mod_act, start_act;
  logic             cnt_wr;
  logic             tick;
  logic             wrap;

  tmr_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt_q), .ovf_evt(wrap), .rdata(rdata), .ps(ps), .sel(clksel),
    .ie(ie), .flag(flag), .mod_buf(mod_buf), .start_buf(start_buf),
    .cnt_wr(cnt_wr)
  );

  tmr_prescale #(.EXP_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(clksel == SEL_SYS), .ps(ps), .tick(tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(clksel == SEL_STOP),
    .cnt_wr(cnt_wr), .mod_buf(mod_buf), .start_buf(start_buf),
    .cnt(cnt_q), .mod_act(mod_act), .start_act(start_act), .wrap(wrap)
  );

  assign irq = flag && ie;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [1:0]    clksel,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] mod_act,
  input logic [CW-1:0] start_act,
  input logic          flag
);
  logic cnt_hit;
  assign cnt_hit = wr_en && (addr == AW'(8'h04));

  // R6
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clksel != 2'd1 && !cnt_hit) |=> (cnt == $past(cnt)));

  // R3
  no_tick_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clksel != 2'd1) |-> !tick);

  // R5
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_hit && cnt == mod_act) |=> flag);

  // R5
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick && !cnt_hit && cnt == mod_act));

  // R7
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit |=> (cnt == $past(start_act)));

  // R8
  shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clksel != 2'd0) |=> ($stable(mod_act) && $stable(start_act)));
endmodule

bind prescaled_modulo_timer tmr_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .clksel(clksel),
  .tick(tick), .cnt(cnt_q), .mod_act(mod_act), .start_act(start_act),
  .flag(flag)
);

// File: tb/prescaled_modulo_timer_test.sv
`timescale 1ns/1ps
module prescaled_modulo_timer_test;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_CNT  = 8'h04;
  localparam logic [7:0] A_MOD  = 8'h08;
  localparam logic [7:0] A_INIT = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  prescaled_modulo_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic logic [31:0] ctl(input int ie, input int sel, input int ps);
    return 32'((ie << 6) | (sel << 3) | ps);
  endfunction

  // stop, program shadows, let them reach the active copies, load counter
  task automatic setup(input int md, input int st);
    wr(A_CTRL, 32'h0);
    wr(A_MOD, 32'(md));
    wr(A_INIT, 32'(st));
    wr(A_CNT, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      report;
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    int md, st, len, nmax, t, ie;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_MOD, v);  chk("R1 modulo", v, 0);
    rd(A_INIT, v); chk("R1 start", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 map, width and unmapped address
    wr(A_MOD, 32'hABCD_0005);
    rd(A_MOD, v); chk("R2 modulo upper bits dropped", v, 32'h5);
    wr(A_INIT, 32'h1234_0002);
    rd(A_INIT, v); chk("R2 start upper bits dropped", v, 32'h2);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R2 unmapped read", v, 0);
    rd(A_CTRL, v); chk("R2 unmapped write ignored", v, 0);

    // R3 R4 R5 R10 sweep
    for (int p = 0; p < 4; p++) begin
      for (int mi = 0; mi < 4; mi++) begin
        for (int ii = 0; ii < 2; ii++) begin
          md = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 3 : 6;
          st = ii ? md / 2 : 0;
          ie = (p + mi) % 2;
          len = md - st + 1;
          nmax = (2 * len + 1) << p;
          setup(md, st);
          wr(A_CTRL, ctl(ie, 1, p));
          for (int n = 1; n <= nmax; n++) begin
            @(negedge clk);
            t = n >> p;
            rd(A_CNT, v);
            chk("R3 R4 sweep count", v, 32'(st + (t % len)));
            rd(A_CTRL, c);
            chk("R5 sweep flag", {31'b0, c[7]}, (t >= len) ? 1 : 0);
            chk("R10 sweep irq", {31'b0, irq}, (t >= len && ie == 1) ? 1 : 0);
          end
        end
      end
    end

    // R7 counter write reloads start, overrides tick
    setup(9, 2);
    wr(A_CTRL, ctl(0, 1, 0));
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R7 pre-load count", v, 5);
    wr(A_CNT, 32'h0000_1234);
    rd(A_CNT, v); chk("R7 count write loads start", v, 2);
    @(negedge clk);
    rd(A_CNT, v); chk("R7 counts on after load", v, 3);

    // R6 prescaler phase cleared on stop
    setup(100, 0);
    wr(A_CTRL, ctl(0, 1, 2));
    repeat (5) @(negedge clk);
    wr(A_CTRL, ctl(0, 0, 2));
    rd(A_CNT, v); chk("R6 count after stop", v, 1);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R6 held while stopped", v, 1);
    wr(A_CTRL, ctl(0, 1, 2));
    repeat (2) @(negedge clk);
    rd(A_CNT, v); chk("R6 no early tick after restart", v, 1);
    repeat (2) @(negedge clk);
    rd(A_CNT, v); chk("R6 tick after full divide", v, 2);

    // R6 select value 2 does not run
    wr(A_CTRL, ctl(0, 2, 0));
    rd(A_CNT, v); c = v;
    repeat (6) @(negedge clk);
    rd(A_CNT, v); chk("R6 select 2 holds count", v, c);

    // R8 modulo change while running is deferred
    setup(3, 0);
    wr(A_CTRL, ctl(0, 1, 0));
    repeat (2) @(negedge clk);
    wr(A_MOD, 32'd10);
    repeat (6) @(negedge clk);
    rd(A_CNT, v); chk("R8 old modulo still active", v, 2);
    rd(A_MOD, v); chk("R8 read returns shadow", v, 10);
    setup(10, 0);
    wr(A_CTRL, ctl(0, 1, 0));
    repeat (8) @(negedge clk);
    rd(A_CNT, v); chk("R8 new modulo after stop", v, 8);

    // R9 coincident wrap keeps flag, clear, write-1 ignored
    setup(0, 0);
    wr(A_CTRL, ctl(1, 1, 0));
    repeat (2) @(negedge clk);
    rd(A_CTRL, v); chk("R5 flag after wrap", {31'b0, v[7]}, 1);
    wr(A_CTRL, ctl(1, 1, 0));
    rd(A_CTRL, v); chk("R9 wrap beats clear", {31'b0, v[7]}, 1);
    chk("R10 irq with flag and enable", {31'b0, irq}, 1);
    wr(A_CTRL, ctl(1, 0, 0) | 32'h80);
    rd(A_CTRL, v); chk("R9 write 1 keeps flag", {31'b0, v[7]}, 1);
    wr(A_CTRL, ctl(1, 0, 0));
    rd(A_CTRL, v); chk("R9 write 0 clears flag", {31'b0, v[7]}, 0);
    chk("R10 irq low after clear", {31'b0, irq}, 0);
    wr(A_CTRL, 32'h80);
    rd(A_CTRL, v); chk("R9 write 1 does not set flag", {31'b0, v[7]}, 0);

    done = 1'b1;
    report;
    $finish;
  end
endmodule